// File: doc/BRIEF.md
# Trace Message Queue with Overrun Recovery

This block sits between the trace message generators and the trace output port. It buffers tagged messages in a small FIFO. Each message carries a data word, a length in bits and a 2-bit type tag (watchpoint, ownership, branch or data). The output port drains the FIFO with a valid/ready handshake.

When a message arrives while the FIFO is full, the queue enters a drain mode. In that mode it discards every incoming message and keeps a sticky mask of the types it has thrown away. Reads continue normally. When the queue is completely empty, the block enqueues one error message whose payload carries the dropped-type mask. In the same step it pulses a sync request, so that the branch trace generator makes its next branch message a synchronizing one. Normal acceptance then resumes.

Top module: `trace_ovr_fifo`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, rd_valid_o and sync_req_o are 0.
- R2: In normal mode, a write made while the queue is not full is accepted. Messages appear on the read port in write order, with data, length and type unchanged and rd_err_o = 0. The head stays stable while rd_valid_o is 1 and rd_ready_i is 0.
- R3: The queue holds DEPTH messages (default 8): DEPTH writes with no reads are all accepted and read back in order.
- R4: A write that arrives while DEPTH messages are held is dropped and starts drain mode. This holds even if a read happens in the same cycle.
- R5: In drain mode every incoming write is dropped. Only the messages held before the overrun are read out.
- R6: When the queue is empty in drain mode, exactly one error message is enqueued on the next clock edge. Its fields are rd_err_o = 1, rd_type_o = 0, rd_len_o = 10, data bits [5:0] = 6'b001000, data bits [9:6] = dropped-type mask, and the upper data bits 0.
- R7: Bit i of the mask is set when a dropped write carried type code i (0 watchpoint, 1 ownership, 2 branch, 3 data). The mask covers the overrunning write, writes during the drain, and a write in the injecting cycle. It is cleared once the error message is written.
- R8: sync_req_o is high for exactly one cycle, the cycle in which the error message first becomes visible, and is low at all other times.
- R9: After the error message is enqueued, the queue accepts writes normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write strobe from the generators |
| wr_data_i | input | DATA_W | Message payload |
| wr_len_i | input | LEN_W | Message length in bits |
| wr_type_i | input | 2 | Type tag: 0 watchpoint, 1 ownership, 2 branch, 3 data |
| rd_valid_o | output | 1 | Head message present |
| rd_ready_i | input | 1 | Consumer takes the head |
| rd_data_o | output | DATA_W | Head payload |
| rd_len_o | output | LEN_W | Head length |
| rd_type_o | output | 2 | Head type tag |
| rd_err_o | output | 1 | Head is an overrun error message |
| sync_req_o | output | 1 | One-cycle request for a synchronizing branch message |

## Verification
An accepted write becomes visible at the head one clock edge after it is driven, and a pop exposes the next entry one edge later. The error message and sync_req_o appear together one edge after the queue is first seen empty while draining. The bench drives on falling edges and samples outputs on the following falling edge, so each result is read one edge after its stimulus. It sweeps every fill level up to DEPTH and every pairing of overrunning type with in-drain type. It computes the expected masks and payloads arithmetically.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic [1:0] {
    MT_WATCH  = 2'd0,
    MT_OWN    = 2'd1,
    MT_BRANCH = 2'd2,
    MT_DATA   = 2'd3
  } msg_type_e;

  localparam int unsigned NUM_TYPES = 4;
  localparam logic [5:0]  ERR_TCODE = 6'b001000;
  localparam int unsigned ERR_LEN   = 10;
endpackage

// File: rtl/tq_storage.sv
module tq_storage #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 41,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);

  assert_no_push_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_count_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/tq_ovr_ctrl.sv
module tq_ovr_ctrl
  import tq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [1:0]           wr_type_i,
  input  logic                 full_i,
  input  logic                 empty_i,
  output logic                 push_o,
  output logic                 inject_o,
  output logic [NUM_TYPES-1:0] err_mask_o,
  output logic                 drain_o,
  output logic                 sync_req_o
);
  typedef enum logic {ST_PASS, ST_DRAIN} ctrl_st_e;

  ctrl_st_e             st_q;
  logic [NUM_TYPES-1:0] mask_q, hit;
  logic                 sync_q;

  assign hit        = wr_valid_i ? (NUM_TYPES'(1) << wr_type_i) : '0;
  assign drain_o    = (st_q == ST_DRAIN);
  assign inject_o   = drain_o && empty_i;
  assign push_o     = (!drain_o && wr_valid_i && !full_i) || inject_o;
  assign err_mask_o = mask_q | hit;  // drop in the injecting cycle is reported too
  assign sync_req_o = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PASS;
      mask_q <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= inject_o;
      unique case (st_q)
        ST_PASS: if (wr_valid_i && full_i) begin
          st_q   <= ST_DRAIN;
          mask_q <= mask_q | hit;
        end
        ST_DRAIN: if (empty_i) begin
          st_q   <= ST_PASS;
          mask_q <= '0;
        end else begin
          mask_q <= mask_q | hit;
        end
        default: st_q <= ST_PASS;
      endcase
    end
  end

  assert_mask_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |=> (mask_q == '0));
  assert_sync_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req_o |=> !sync_req_o);
  assert_sync_leaves_drain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req_o |-> !drain_o);
endmodule

// File: rtl/trace_ovr_fifo.sv
module trace_ovr_fifo
  import tq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [1:0]        wr_type_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic [1:0]        rd_type_o,
  output logic              rd_err_o,
  output logic              sync_req_o
);
  localparam int unsigned ENT_W = 1 + 2 + LEN_W + DATA_W;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic                 push, pop, inject, drain, full, empty;
  logic [NUM_TYPES-1:0] err_mask;
  logic [ENT_W-1:0]     wentry, rentry;
  logic [CW-1:0]        count;

  tq_ovr_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_type_i  (wr_type_i),
    .full_i     (full),
    .empty_i    (empty),
    .push_o     (push),
    .inject_o   (inject),
    .err_mask_o (err_mask),
    .drain_o    (drain),
    .sync_req_o (sync_req_o)
  );

  assign wentry = inject
    ? {1'b1, 2'b00, LEN_W'(ERR_LEN), DATA_W'({err_mask, ERR_TCODE})}
    : {1'b0, wr_type_i, wr_len_i, wr_data_i};

  tq_storage #(.DEPTH(DEPTH), .W(ENT_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wentry),
    .pop_i   (pop),
    .rdata_o (rentry),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  assign rd_valid_o = !empty;
  assign pop        = rd_valid_o && rd_ready_i;
  assign {rd_err_o, rd_type_o, rd_len_o, rd_data_o} = rentry;

  assert_drain_no_growth_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain && !empty) |=> (count <= $past(count)));
  assert_err_has_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_err_o) |-> (rd_data_o[5:0] == ERR_TCODE && rd_data_o[9:6] != '0));
  assert_hold_head_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rentry)));
endmodule

// File: tb/test_trace_ovr_fifo.sv
module test_trace_ovr_fifo;
  localparam int DEPTH = 8, DATA_W = 32, LEN_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic [LEN_W-1:0] wr_len = '0, rd_len;
  logic [1:0] wr_type = '0, rd_type;
  logic rd_valid, rd_err, sync_req;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  trace_ovr_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_trace_ovr_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_len_i(wr_len), .wr_type_i(wr_type), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .rd_data_o(rd_data), .rd_len_o(rd_len), .rd_type_o(rd_type), .rd_err_o(rd_err),
    .sync_req_o(sync_req));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  function automatic logic [31:0] pat(input int n, input int i);
    return {8'h5A, 8'(n), 8'(i), 8'(n * 7 + i * 3)};
  endfunction

  task automatic push(input logic [31:0] d, input int len, input int typ);
    wr_valid = 1'b1; wr_data = d; wr_len = LEN_W'(len); wr_type = 2'(typ);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic head(input logic [31:0] d, input int len, input int typ, input string req);
    check(rd_valid == 1'b1, req, "rd_valid", rd_valid, 1);
    check(rd_data == d, req, "rd_data", rd_data, d);
    check(rd_len == LEN_W'(len), req, "rd_len", rd_len, len);
    check(rd_type == 2'(typ), req, "rd_type", rd_type, typ);
    check(rd_err == 1'b0, req, "rd_err", rd_err, 0);
  endtask

  task automatic err_head(input int mask);
    check(rd_valid == 1'b1, "R6", "err rd_valid", rd_valid, 1);
    check(rd_err == 1'b1, "R6", "err flag", rd_err, 1);
    check(rd_data[5:0] == 6'b001000, "R6", "err code", rd_data[5:0], 8);
    check(rd_data[31:10] == '0, "R6", "err upper", rd_data[31:10], 0);
    check(rd_len == LEN_W'(10), "R6", "err len", rd_len, 10);
    check(rd_type == 2'd0, "R6", "err type", rd_type, 0);
    check(rd_data[9:6] == 4'(mask), "R7", "err mask", rd_data[9:6], mask);
    check(sync_req == 1'b1, "R8", "sync pulse", sync_req, 1);
  endtask

  task automatic fill_full(input int tag);
    for (int i = 0; i < DEPTH; i++) push(pat(tag, i), 20 + i, 2);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
    check(sync_req == 1'b0, "R1", "sync in reset", sync_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    check(sync_req == 1'b0, "R1", "sync after reset", sync_req, 0);

    // fill-level sweep: R2 ordering and hold, R3 full capacity
    for (int n = 1; n <= DEPTH; n++) begin
      string rq;
      rq = (n == DEPTH) ? "R3" : "R2";
      for (int i = 0; i < n; i++) push(pat(n, i), (n + i) % 64, i % 4);
      head(pat(n, 0), n % 64, 0, rq);
      repeat (2) @(negedge clk);
      head(pat(n, 0), n % 64, 0, "R2");
      for (int i = 0; i < n; i++) begin
        head(pat(n, i), (n + i) % 64, i % 4, rq);
        pop();
      end
      check(rd_valid == 1'b0, rq, "empty after drain", rd_valid, 0);
    end

    // overrun sweep: overrunning type t, in-drain type u, injecting-cycle type v
    for (int t = 0; t < 4; t++) begin
      for (int u = 0; u < 4; u++) begin
        int v, exp_mask, tag;
        v = (t + 2) % 4;
        tag = 16 + t * 4 + u;
        exp_mask = (1 << t) | (1 << u) | (1 << v);
        fill_full(tag);
        push(32'hDEAD0000 | 32'(tag), 1, t);
        head(pat(tag, 0), 20, 2, "R4");
        for (int k = 0; k < DEPTH; k++) begin
          head(pat(tag, k), 20 + k, 2, "R5");
          check(sync_req == 1'b0, "R8", "no sync while draining", sync_req, 0);
          wr_valid = 1'b1; wr_type = 2'(u); wr_data = 32'hBAD00000 | 32'(k);
          rd_ready = 1'b1;
          @(negedge clk);
        end
        rd_ready = 1'b0;
        check(rd_valid == 1'b0, "R5", "drop during drain", rd_valid, 0);
        wr_type = 2'(v);
        @(negedge clk);
        wr_valid = 1'b0;
        err_head(exp_mask);
        pop();
        check(sync_req == 1'b0, "R8", "sync one cycle", sync_req, 0);
        check(rd_valid == 1'b0, "R6", "single error msg", rd_valid, 0);
        push(pat(200, tag), 5, u);
        head(pat(200, tag), 5, u, "R9");
        pop();
      end
    end

    // R4 with a read in the overrun cycle; R7 mask starts clean
    fill_full(99);
    wr_valid = 1'b1; wr_type = 2'd3; wr_data = 32'hDEADBEEF; rd_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0;
    for (int k = 1; k < DEPTH; k++) begin
      head(pat(99, k), 20 + k, 2, "R4");
      pop();
    end
    check(rd_valid == 1'b0, "R4", "overrun despite read", rd_valid, 0);
    @(negedge clk);
    err_head(8);
    pop();
    check(rd_valid == 1'b0, "R6", "single error msg", rd_valid, 0);

    summary();
  end
endmodule